// File: doc/BRIEF.md
# Selectable Decade Frequency Divider

This block divides an incoming clock by a power of ten picked from four ratios: 10, 100, 1,000 or 10,000. It is a chain of four decimal counting stages. A two-bit select code picks which stage feeds the output. The block gives a 50% duty square wave, not a one-cycle pulse. Everything in it moves on the high-to-low edge of the input clock. An active-high reset clears every stage and drives the output low.

Each decimal stage has two parts. The first is a five-state counter, with states `PH0`, `PH1`, `PH2`, `PH3` and `PH4`. Each enable moves it to the next state, and from `PH4` it wraps back to `PH0`. The second is a half-period flag that toggles on every wrap out of `PH4`. The stage's square output is this flag. The stage raises a single-cycle carry in the one cycle where three things hold: it is enabled, it is in `PH4`, and its flag is high. That carry is the enable of the next stage, so every flop runs from the same clock edge.

The selected tap passes through a two-state output machine. Its states are `OUT_LOW` and `OUT_HIGH`. It goes to `OUT_HIGH` when the tap is high and to `OUT_LOW` when the tap is low. This makes the output a flop, so a change on the select lines cannot cause a combinational glitch.

Top module: `decade_chain_divider`

## Requirements
- R1: All state, including the output, changes only on falling edges of `clk_in`. The output holds its value across rising edges.
- R2: While `rst` is high, the output is low and every stage is held at zero.
- R3: The output ratio follows `sel_i` = {select-2, select-1}. Code 2'b00 divides by 10,000, 2'b01 by 1,000, 2'b10 by 100 and 2'b11 by 10.
- R4: Stage k advances only in a cycle where stage k-1 gives its carry. A carry from stage k therefore implies a carry from stage k-1 in the same cycle.
- R5: The output is a square wave. For a ratio N it stays high for N/2 falling edges and then low for N/2 falling edges.
- R6: The output is registered. Whenever it changes, its new value equals the selected tap as sampled on the previous falling edge.
- R7: After reset is released, the output is low. It first goes high on falling edge number N/2+1.
- R8: Raising reset in the middle of a count drives the output low at once. After release, the count restarts from zero, so the first high comes again at edge N/2+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; state advances on its falling edge |
| rst | input | 1 | Active-high asynchronous clear of all stages and the output |
| sel_i | input | SEL_W (2) | Ratio code: bit 1 is select-2, bit 0 is select-1 |
| div_o | output | 1 | Divided square-wave output |

## Verification
The bench builds the block with its default of four stages. This brings every tap of the chain within reach, including the deepest ratio of 10,000, where all four carries line up. Short runs are enough to measure whole high and low phases at each ratio. Reset is also tested part-way through a count at ratios 10 and 100, so the restart can be seen both in the first stage and in a stage driven by a carry.

// File: rtl/decdiv_pkg.sv
package decdiv_pkg;

    // five-state counter inside each decimal stage
    typedef enum logic [2:0] {
        PH0 = 3'd0,
        PH1 = 3'd1,
        PH2 = 3'd2,
        PH3 = 3'd3,
        PH4 = 3'd4
    } quin_t;

    // registered output level
    typedef enum logic {
        OUT_LOW  = 1'b0,
        OUT_HIGH = 1'b1
    } level_t;

    // width of a select code able to address n taps
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/decade_stage.sv
module decade_stage
    import decdiv_pkg::*;
(
    input  logic clk_in,
    input  logic rst,
    input  logic en_i,
    output logic sq_o,
    output logic carry_o
);

    quin_t q_state;
    quin_t q_next;
    logic  half_q;
    logic  half_next;

    // state register
    always_ff @(negedge clk_in or posedge rst) begin
        if (rst) begin
            q_state <= PH0;
            half_q  <= 1'b0;
        end else begin
            q_state <= q_next;
            half_q  <= half_next;
        end
    end

    // transitions: PH0->PH1->PH2->PH3->PH4->PH0, flag toggles on wrap
    always_comb begin
        q_next    = q_state;
        half_next = half_q;
        if (en_i) begin
            unique case (q_state)
                PH0: q_next = PH1;
                PH1: q_next = PH2;
                PH2: q_next = PH3;
                PH3: q_next = PH4;
                PH4: begin
                    q_next    = PH0;
                    half_next = ~half_q;
                end
                default: q_next = PH0;
            endcase
        end
    end

    // outputs
    always_comb begin
        sq_o    = half_q;
        carry_o = en_i && (q_state == PH4) && half_q;
    end

endmodule

// File: rtl/tap_selector.sv
module tap_selector #(
    parameter int NUM_STAGES = 4,
    parameter int SEL_W      = 2
) (
    input  logic [NUM_STAGES-1:0] sq_i,
    input  logic [SEL_W-1:0]      sel_i,
    output logic                  tap_o
);

    // code 0 picks the deepest stage, the top code picks the first stage
    int pick;

    always_comb begin
        pick  = NUM_STAGES - 1 - int'(sel_i);
        tap_o = sq_i[0];
        for (int k = 0; k < NUM_STAGES; k++) begin
            if (k == pick) begin
                tap_o = sq_i[k];
            end
        end
    end

endmodule

// File: rtl/out_shaper.sv
module out_shaper
    import decdiv_pkg::*;
(
    input  logic clk_in,
    input  logic rst,
    input  logic tap_i,
    output logic div_o
);

    level_t lvl_state;
    level_t lvl_next;

    // state register
    always_ff @(negedge clk_in or posedge rst) begin
        if (rst) begin
            lvl_state <= OUT_LOW;
        end else begin
            lvl_state <= lvl_next;
        end
    end

    // transitions: OUT_LOW->OUT_HIGH on high tap, OUT_HIGH->OUT_LOW on low tap
    always_comb begin
        lvl_next = lvl_state;
        unique case (lvl_state)
            OUT_LOW:  if (tap_i)  lvl_next = OUT_HIGH;
            OUT_HIGH: if (!tap_i) lvl_next = OUT_LOW;
            default:  lvl_next = OUT_LOW;
        endcase
    end

    // output
    always_comb begin
        div_o = (lvl_state == OUT_HIGH);
    end

endmodule

// File: rtl/decade_chain_divider.sv
module decade_chain_divider
    import decdiv_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    localparam int SEL_W     = sel_width(NUM_STAGES)
) (
    input  logic             clk_in,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    output logic             div_o
);

    logic [NUM_STAGES-1:0] stage_en;
    logic [NUM_STAGES-1:0] stage_sq;
    logic [NUM_STAGES-1:0] stage_carry;
    logic                  tap_w;

    assign stage_en[0] = 1'b1;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        if (k > 0) begin : g_link
            assign stage_en[k] = stage_carry[k-1];
        end
        decade_stage u_stage (
            .clk_in  (clk_in),
            .rst     (rst),
            .en_i    (stage_en[k]),
            .sq_o    (stage_sq[k]),
            .carry_o (stage_carry[k])
        );
    end

    tap_selector #(
        .NUM_STAGES (NUM_STAGES),
        .SEL_W      (SEL_W)
    ) u_sel (
        .sq_i  (stage_sq),
        .sel_i (sel_i),
        .tap_o (tap_w)
    );

    out_shaper u_out (
        .clk_in (clk_in),
        .rst    (rst),
        .tap_i  (tap_w),
        .div_o  (div_o)
    );

endmodule

// File: rtl/decdiv_checker.sv
module decdiv_checker #(
    parameter int NUM_STAGES = 4,
    parameter int SEL_W      = 2
) (
    input logic                  clk_in,
    input logic                  rst,
    input logic [SEL_W-1:0]      sel_i,
    input logic                  div_o,
    input logic [NUM_STAGES-1:0] stage_sq,
    input logic [NUM_STAGES-1:0] stage_carry,
    input logic                  tap
);

    AST_HELD_LOW: assert property (@(negedge clk_in) rst |-> (!div_o && (stage_sq == '0))); // R2

    AST_OUT_FOLLOWS_TAP: assert property (@(negedge clk_in) disable iff (rst) !$stable(div_o) |-> (div_o == $past(tap))); // R6

    AST_SEL_KNOWN: assert property (@(negedge clk_in) disable iff (rst) !$isunknown(sel_i)); // R3

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_chk
        AST_SQUARE_FALL: assert property (@(negedge clk_in) disable iff (rst) stage_carry[k] |=> $fell(stage_sq[k])); // R5
        if (k > 0) begin : g_chain
            AST_CARRY_CHAIN: assert property (@(negedge clk_in) disable iff (rst) stage_carry[k] |-> stage_carry[k-1]); // R4
        end
    end

endmodule

bind decade_chain_divider decdiv_checker #(
    .NUM_STAGES (NUM_STAGES),
    .SEL_W      (SEL_W)
) u_chk (
    .clk_in      (clk_in),
    .rst         (rst),
    .sel_i       (sel_i),
    .div_o       (div_o),
    .stage_sq    (stage_sq),
    .stage_carry (stage_carry),
    .tap         (tap_w)
);

// File: tb/sim_decade_chain_divider.sv
`timescale 1ns/1ps
module sim_decade_chain_divider;

    logic       clk_in = 1'b0;
    logic       rst    = 1'b0;
    logic [1:0] sel_i  = 2'b11;
    logic       div_o;

    int n_checks = 0;
    int n_fails  = 0;

    decade_chain_divider u0 (
        .clk_in (clk_in),
        .rst    (rst),
        .sel_i  (sel_i),
        .div_o  (div_o)
    );

    always #5 clk_in = ~clk_in;

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // count falling edges until div_o reaches lvl; sample 1 ns after each edge
    task automatic edges_until(input logic lvl, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(negedge clk_in);
            #1;
            n++;
            if (div_o == lvl) break;
        end
    endtask

    task automatic hold_reset(input logic [1:0] code);
        @(posedge clk_in);
        sel_i = code;
        rst   = 1'b1;
        repeat (3) @(negedge clk_in);
        #1;
        check(div_o == 1'b0, "R2", int'(div_o), 0);
        @(posedge clk_in);
        rst = 1'b0;
    endtask

    task automatic run_ratio(input logic [1:0] code, input int ratio);
        int n;
        hold_reset(code);
        #1;
        check(div_o == 1'b0, "R7", int'(div_o), 0);
        edges_until(1'b1, ratio + 10, n);
        check(n == ratio / 2 + 1, "R7", n, ratio / 2 + 1);
        @(posedge clk_in);
        #1;
        check(div_o == 1'b1, "R1", int'(div_o), 1);   // holds across rising edge
        edges_until(1'b0, ratio + 10, n);
        check(n == ratio / 2, "R5", n, ratio / 2);
        edges_until(1'b1, ratio + 10, n);
        check(n == ratio / 2, "R3", n, ratio / 2);
        edges_until(1'b0, ratio + 10, n);
        check(n == ratio / 2, "R5", n, ratio / 2);
    endtask

    task automatic reset_mid_count(input logic [1:0] code, input int ratio, input int run);
        int n;
        hold_reset(code);
        repeat (run) @(negedge clk_in);
        @(posedge clk_in);
        rst = 1'b1;
        #1;
        check(div_o == 1'b0, "R8", int'(div_o), 0);
        repeat (2) @(negedge clk_in);
        @(posedge clk_in);
        rst = 1'b0;
        edges_until(1'b1, ratio + 10, n);
        check(n == ratio / 2 + 1, "R8", n, ratio / 2 + 1);
    endtask

    initial begin
        repeat (150000) @(negedge clk_in);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2;
        rst = 1'b1;
        run_ratio(2'b11, 10);      // R3 divide by 10
        run_ratio(2'b10, 100);     // R3 divide by 100
        run_ratio(2'b01, 1000);    // R3 divide by 1,000
        run_ratio(2'b00, 10000);   // R3 divide by 10,000
        reset_mid_count(2'b11, 10, 7);
        reset_mid_count(2'b10, 100, 63);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule